// File: doc/BRIEF.md
# Contention-Adaptive Sync-Miss Backoff

This per-core unit throttles local synchronization read misses once other cores are seen competing for the same synchronization words. Each remote synchronization read that targets a word this core holds arrives as a one-cycle pulse. The unit uses these pulses to grow a delay amount. The next local synchronization miss is then held back by that many cycles before it is released to the memory system.

Adaptation works at two levels. A delay accumulator grows by the current step size on every remote pulse. The step size grows by a configured default amount on every Nth remote pulse. Under sustained contention the delay therefore grows faster and faster. A released miss empties the accumulator and keeps the step size. Both values stop at their maximum and never wrap.

The local miss path uses a request/grant handshake. The requester raises `miss_req_i` and holds it until it sees `miss_grant_o` high at a clock edge.

Top module: `sync_backoff`

## Requirements
- R1: After reset the delay and the step size are both 0, and `miss_grant_o` is low while `miss_req_i` is low.
- R2: When the accumulated delay is 0 and no miss is being held, a raised `miss_req_i` is granted in the same cycle, combinationally.
- R3: Each cycle with `remote_rd_i` high adds the step size, as it was before that edge, to the delay. With no pulse and no grant, the delay holds its value.
- R4: A modulo-N count of remote pulses raises the step size by `step_i` on every Nth pulse, where N is `period_i`. With `period_i` = 0 the step size never changes.
- R5: A miss first requested in cycle t with delay B is granted in cycle t+B. B is sampled in cycle t, so remote pulses during the wait do not change the grant cycle.
- R6: A grant clears the delay to 0 and keeps the step size. A remote pulse in the grant cycle leaves the delay equal to the step size.
- R7: The delay saturates at 2^B_W-1 and the step size saturates at 2^I_W-1. Neither wraps.
- R8: `miss_grant_o` is never high while `miss_req_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| remote_rd_i | input | 1 | One-cycle pulse per remote synchronization read to a held word |
| step_i | input | I_W | Default amount added to the step size every Nth pulse |
| period_i | input | N_W | N, the pulse count between step-size raises; 0 disables raising |
| miss_req_i | input | 1 | Local synchronization miss request, held until granted |
| miss_grant_o | output | 1 | Miss may be issued this cycle |

## Verification
Neither counter is visible at the ports, so every internal fault shows up only as a grant latency. A wrong delay shows in the latency of the very next miss. A step size that is wrong or wrapped shows only after a further remote pulse, in the miss that follows it. A modulo count that is off by one shifts the point where the step size rises, and that change appears only after a whole period of pulses. The stimulus therefore chains pulses and misses, so that each piece of state is converted into a grant cycle.

// File: rtl/sync_backoff_pkg.sv
`timescale 1ns/1ps
package sync_backoff_pkg;
  typedef enum logic {
    GATE_IDLE = 1'b0,
    GATE_WAIT = 1'b1
  } gate_state_e;
endpackage

// File: rtl/sync_backoff_step.sv
`timescale 1ns/1ps
// Step-size register raised every Nth remote pulse.
module sync_backoff_step #(
  parameter int unsigned I_W = 8,
  parameter int unsigned N_W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           hit_i,
  input  logic [I_W-1:0] step_i,
  input  logic [N_W-1:0] period_i,
  output logic [I_W-1:0] incr_o
);
  localparam logic [I_W-1:0] I_MAX = '1;

  logic [N_W-1:0] cnt_q;
  logic [N_W:0]   cnt_inc;
  logic           roll;
  logic [I_W:0]   incr_sum;
  logic [I_W-1:0] incr_q;

  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  // >= keeps the count bounded if the period shrinks mid-run
  assign roll     = (period_i != '0) && (cnt_inc >= {1'b0, period_i});
  assign incr_sum = {1'b0, incr_q} + {1'b0, step_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      incr_q <= '0;
    end else if (hit_i) begin
      if (roll) begin
        cnt_q  <= '0;
        incr_q <= incr_sum[I_W] ? I_MAX : incr_sum[I_W-1:0];
      end else begin
        cnt_q  <= cnt_inc[N_W-1:0];
      end
    end
  end

  assign incr_o = incr_q;
endmodule

// File: rtl/sync_backoff_acc.sv
`timescale 1ns/1ps
// Delay accumulator: cleared on grant, raised by the step size on each pulse.
module sync_backoff_acc #(
  parameter int unsigned B_W = 8,
  parameter int unsigned I_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           hit_i,
  input  logic           clr_i,
  input  logic [I_W-1:0] incr_i,
  output logic [B_W-1:0] backoff_o
);
  localparam logic [B_W-1:0] B_MAX = '1;

  logic [B_W-1:0] b_q;
  logic [B_W-1:0] base;
  logic [B_W:0]   sum;

  assign base = clr_i ? '0 : b_q;
  assign sum  = {1'b0, base} + {{(B_W+1-I_W){1'b0}}, incr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    b_q <= '0;
    else if (hit_i) b_q <= sum[B_W] ? B_MAX : sum[B_W-1:0];
    else            b_q <= base;
  end

  assign backoff_o = b_q;
endmodule

// File: rtl/sync_backoff_gate.sv
`timescale 1ns/1ps
// Holds a miss request for the delay sampled when it first appears.
module sync_backoff_gate
  import sync_backoff_pkg::*;
#(
  parameter int unsigned B_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic [B_W-1:0] backoff_i,
  output logic           gnt_o,
  output logic           busy_o
);
  gate_state_e    st_q;
  logic [B_W-1:0] wait_q;

  always_comb begin
    gnt_o = 1'b0;
    if (req_i) begin
      if (st_q == GATE_IDLE) gnt_o = (backoff_i == '0);
      else                   gnt_o = (wait_q == '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= GATE_IDLE;
      wait_q <= '0;
    end else begin
      unique case (st_q)
        GATE_IDLE: if (req_i && backoff_i != '0) begin
          st_q   <= GATE_WAIT;
          wait_q <= backoff_i - 1'b1;
        end
        GATE_WAIT: begin
          if (!req_i || wait_q == '0) st_q <= GATE_IDLE;
          else                        wait_q <= wait_q - 1'b1;
        end
        default: st_q <= GATE_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q == GATE_WAIT);
endmodule

// File: rtl/sync_backoff.sv
`timescale 1ns/1ps
module sync_backoff #(
  parameter int unsigned B_W = 8,
  parameter int unsigned I_W = 8,
  parameter int unsigned N_W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           remote_rd_i,
  input  logic [I_W-1:0] step_i,
  input  logic [N_W-1:0] period_i,
  input  logic           miss_req_i,
  output logic           miss_grant_o
);
  logic [I_W-1:0] incr_q;
  logic [B_W-1:0] backoff_q;
  logic           gate_busy;

  sync_backoff_step #(.I_W(I_W), .N_W(N_W)) u_step (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (remote_rd_i),
    .step_i   (step_i),
    .period_i (period_i),
    .incr_o   (incr_q)
  );

  sync_backoff_acc #(.B_W(B_W), .I_W(I_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (remote_rd_i),
    .clr_i     (miss_grant_o),
    .incr_i    (incr_q),
    .backoff_o (backoff_q)
  );

  sync_backoff_gate #(.B_W(B_W)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (miss_req_i),
    .backoff_i (backoff_q),
    .gnt_o     (miss_grant_o),
    .busy_o    (gate_busy)
  );
endmodule

// File: rtl/sync_backoff_chk.sv
`timescale 1ns/1ps
module sync_backoff_chk #(
  parameter int unsigned B_W = 8,
  parameter int unsigned I_W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           remote_rd_i,
  input logic           miss_req_i,
  input logic           miss_grant_o,
  input logic           busy_i,
  input logic [B_W-1:0] backoff_i,
  input logic [I_W-1:0] incr_i
);
  localparam logic [B_W:0] B_MAX_W = {1'b0, {B_W{1'b1}}};

  AST_GNT_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_grant_o |-> miss_req_i); // R8

  AST_ZERO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_req_i && !busy_i && backoff_i == '0) |-> miss_grant_o); // R2

  AST_GNT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_grant_o && !remote_rd_i) |=> backoff_i == '0); // R6

  AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!miss_grant_o && !remote_rd_i) |=> $stable(backoff_i)); // R3

  AST_HIT_ADDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!miss_grant_o && remote_rd_i) |=>
      ({1'b0, backoff_i} ==
       ((({1'b0, $past(backoff_i)} + (B_W+1)'($past(incr_i))) > B_MAX_W) ? B_MAX_W
         : ({1'b0, $past(backoff_i)} + (B_W+1)'($past(incr_i)))))); // R7

  AST_STEP_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> incr_i >= $past(incr_i)); // R4
endmodule

bind sync_backoff sync_backoff_chk #(.B_W(B_W), .I_W(I_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .remote_rd_i  (remote_rd_i),
  .miss_req_i   (miss_req_i),
  .miss_grant_o (miss_grant_o),
  .busy_i       (gate_busy),
  .backoff_i    (backoff_q),
  .incr_i       (incr_q)
);

// File: tb/sync_backoff_bench.sv
`timescale 1ns/1ps
module sync_backoff_bench;
  localparam int B_W = 8;
  localparam int I_W = 8;
  localparam int N_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rem = 1'b0;
  logic req = 1'b0;
  logic [I_W-1:0] step = '0;
  logic [N_W-1:0] period = '0;
  logic gnt;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sync_backoff #(.B_W(B_W), .I_W(I_W), .N_W(N_W)) u_sync_backoff (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .remote_rd_i  (rem),
    .step_i       (step),
    .period_i     (period),
    .miss_req_i   (req),
    .miss_grant_o (gnt)
  );

  // {pulses, step, period, expected latency}; R4 and R5 per row
  localparam int VEC [8][4] = '{
    '{0,   3,  1,  0},
    '{3,   2,  1,  6},
    '{4,   4,  2,  8},
    '{5,   1,  3,  2},
    '{6,   5,  0,  0},
    '{4,  16,  1, 96},
    '{2,  16,  1, 16},
    '{16,  1, 15,  1}
  };

  task automatic check(input string rq, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = 1'b0; rem = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulses(input int k);
    if (k > 0) begin
      @(negedge clk);
      rem = 1'b1;
      repeat (k) @(negedge clk);
      rem = 1'b0;
    end
  endtask

  task automatic miss(output int lat);
    @(negedge clk);
    req = 1'b1;
    #1;
    lat = 0;
    while (!gnt && lat < 2000) begin
      @(negedge clk);
      #1;
      lat++;
    end
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    int lat;
    for (int v = 0; v < 8; v++) begin
      do_reset();
      step = I_W'(VEC[v][1]);
      period = N_W'(VEC[v][2]);
      pulses(VEC[v][0]);
      miss(lat);
      check($sformatf("R5 vec%0d", v), lat, VEC[v][3]);
    end

    // R1: reset state
    do_reset();
    #1 check("R1 idle grant", int'(gnt), 0);
    miss(lat);
    check("R1 first miss", lat, 0);

    // R6: grant clears delay, keeps step
    do_reset();
    step = 8'd4; period = 4'd2;
    pulses(4);                 // delay 8, step 8, count 0
    miss(lat); check("R5 delay 8", lat, 8);
    miss(lat); check("R6 cleared", lat, 0);
    pulses(1);                 // delay 8, count 1
    miss(lat); check("R6 step kept", lat, 8);

    // R2/R3/R6: pulse in the grant cycle; old step 8 added, step becomes 12
    @(negedge clk);
    req = 1'b1; rem = 1'b1;
    #1 check("R2 same-cycle grant", int'(gnt), 1);
    @(negedge clk);
    req = 1'b0; rem = 1'b0;
    miss(lat); check("R6 R3 pulse at grant", lat, 8);

    // R5: pulses during the wait do not move the grant
    pulses(1);                 // delay 12
    fork
      miss(lat);
      begin repeat (3) @(negedge clk); pulses(2); end
    join
    check("R5 wait fixed", lat, 12);
    miss(lat); check("R6 cleared after wait", lat, 0);

    // R7: saturation of both counters
    do_reset();
    step = 8'd200; period = 4'd1;
    pulses(3);
    miss(lat); check("R7 delay saturates", lat, 255);
    pulses(1);
    miss(lat); check("R7 step saturates", lat, 255);

    // R8: no grant without request while delay builds
    do_reset();
    step = 8'd1; period = 4'd1;
    for (int k = 0; k < 4; k++) begin
      pulses(1);
      #1 check("R8 no request", int'(gnt), 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule